// File: doc/BRIEF.md
# Banked Matrix-Vector Multiply Engine

This block multiplies a square matrix of 12-bit signed coefficients by a column vector that arrives one 12-bit signed element per clock cycle. There is one multiply-accumulate unit per output row, so each accepted element updates every row at once. After the last element of a vector is accepted, the finished row sums are saturated to 16 bits and moved into an output register. The output register then shows one result per cycle, while the row accumulators are already free to take the next vector.

A single byte-wide configuration register selects how the engine is shaped. It can run as one 16×16 product fed from the primary data input. It can also run as two independent 8×8 products at the same time. In that second shape, the second product takes its vector either from a secondary input or from the same primary input.

Coefficients are written through a simple indexed port. The port writes a staging store. The arithmetic uses a separate active copy, which is taken from the staging store at the start of each vector.

Top module: `mvm_engine`

## Requirements
- R1: After reset the configuration byte is 0x00, the engine is disabled, and `resValidA`, `resValidB` and `resLast` are low.
- R2: Configuration bit 4 enables the engine, and while it is 0, `dValid` is ignored and no result appears. Bit 1 = 1 selects dual 8×8 operation and bit 1 = 0 selects single 16×16 operation. In dual operation, bit 2 = 1 feeds the second product from `dIn` and bit 2 = 0 feeds it from `rIn`. So 0x12 and 0x16 give dual operation and 0x14 gives single operation.
- R3: A coefficient write stores `coefData` at row `coefSet`, column `coefCol`. In dual operation, rows 0–7 belong to product A and rows 8–15 belong to product B, and both use columns 0–7.
- R4: In single operation, result i = Σ C[i][j]·D[j] for j = 0..15, where D[j] is the j-th element accepted on `dIn` since the vector began.
- R5: In dual operation, product A gives row i (0–7) from `dIn`, and product B gives row 8+i from its selected source. Each is summed over j = 0..7, and `resValidB` is high only in dual operation.
- R6: Each row sum is computed at full precision and then clamped to the range −32768..32767.
- R7: In the cycle after the final element of a vector is accepted, results start to appear, one per cycle. `resIdx` counts 0..N−1 with `resValidA` high. `resA` carries row `resIdx`, `resB` carries row 8+`resIdx`, and `resLast` is high on index N−1. Both result outputs are 0 when not valid.
- R8: A new vector may stream with no idle cycle after the previous one. Its results follow the previous results with no gap.
- R9: A coefficient write made while a vector is in progress, including in the same cycle as its first element, affects only the following vectors.
- R10: A configuration write discards any partly accumulated vector and stops any result sequence that is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgWdata | input | 8 | Configuration byte |
| coefWe | input | 1 | Coefficient write strobe |
| coefSet | input | 4 | Coefficient row (set) index |
| coefCol | input | 4 | Coefficient column index |
| coefData | input | 12 | Signed coefficient value |
| dValid | input | 1 | Vector element valid |
| dIn | input | 12 | Primary signed vector element |
| rIn | input | 12 | Secondary signed vector element (product B) |
| resValidA | output | 1 | `resA` holds a valid result |
| resA | output | 16 | Result row `resIdx` |
| resValidB | output | 1 | `resB` holds a valid result (dual only) |
| resB | output | 16 | Result row 8+`resIdx` |
| resIdx | output | 4 | Index of the result being presented |
| resLast | output | 1 | Final result of the vector |

## Verification
The hardest case to reach is the overlap of one vector's accumulation with three other events: the previous vector's results being presented, a coefficient write landing in the same cycle as the first element, and a write in the middle of the vector. The bench streams two vectors with no gap between them and fires coefficient writes at element 0 and element 3 of the first vector. Its model then uses the old coefficients for the first result set and the new ones for the second. The bench also aborts a half-streamed vector with a configuration write, and drives a run whose sums exceed the 16-bit range in both directions.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  localparam int MaxN   = 16;
  localparam int HalfN  = MaxN / 2;
  localparam int IdxW   = $clog2(MaxN);
  localparam int CoefW  = 12;
  localparam int DataW  = 12;
  localparam int ResW   = 16;
  localparam int ProdW  = CoefW + DataW;
  localparam int AccW   = ProdW + IdxW;
  localparam int CfgW   = 8;
  localparam int CfgEnBit   = 4;
  localparam int CfgDualBit = 1;
  localparam int CfgSrcBit  = 2;

  typedef struct packed {
    logic            accept;  // element taken this cycle
    logic            first;   // element 0 of a vector
    logic            last;    // element N-1 of a vector
    logic            clear;   // discard partial sums
    logic            dual;    // two 8x8 products
    logic            srcDin;  // product B fed from dIn
    logic [IdxW-1:0] col;     // column of the current element
  } mvStrobes_t;

  function automatic logic signed [ResW-1:0] satRes(input logic signed [AccW-1:0] v);
    logic upperOnes;
    logic upperZeros;
    upperOnes  = &v[AccW-2:ResW-1];
    upperZeros = ~|v[AccW-2:ResW-1];
    if (!v[AccW-1] && !upperZeros)
      satRes = {1'b0, {(ResW-1){1'b1}}};
    else if (v[AccW-1] && !upperOnes)
      satRes = {1'b1, {(ResW-1){1'b0}}};
    else
      satRes = v[ResW-1:0];
  endfunction
endpackage

// File: rtl/mvm_ctrl.sv
module mvm_ctrl
  import mvm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [CfgW-1:0] cfgWdata,
  input  logic            dValid,
  output mvStrobes_t      strb,
  output logic            outValidA,
  output logic            outValidB,
  output logic            outLast,
  output logic [IdxW-1:0] outIdx
);
  logic            enReg;
  logic            dualReg;
  logic            srcReg;
  logic [IdxW-1:0] colCnt;
  logic            drainOn;
  logic [IdxW-1:0] drainIdx;
  logic [IdxW-1:0] lastCol;
  logic            accept;
  logic            isLast;
  logic            unusedCfgBits;

  assign unusedCfgBits = ^{cfgWdata[CfgW-1:CfgEnBit+1], cfgWdata[CfgEnBit-1:CfgSrcBit+1],
                           cfgWdata[CfgDualBit-1:0]};

  // configuration register: only the decoded bits are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      dualReg <= 1'b0;
      srcReg  <= 1'b0;
    end else if (cfgWe) begin
      enReg   <= cfgWdata[CfgEnBit];
      dualReg <= cfgWdata[CfgDualBit];
      srcReg  <= cfgWdata[CfgSrcBit];
    end
  end

  assign lastCol = dualReg ? IdxW'(HalfN - 1) : IdxW'(MaxN - 1);
  assign accept  = dValid && enReg && !cfgWe;
  assign isLast  = accept && (colCnt == lastCol);

  // column counter for the vector being accumulated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      colCnt <= '0;
    else if (cfgWe)
      colCnt <= '0;
    else if (accept)
      colCnt <= isLast ? '0 : colCnt + 1'b1;
  end

  // result presentation counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainOn  <= 1'b0;
      drainIdx <= '0;
    end else if (cfgWe) begin
      drainOn  <= 1'b0;
      drainIdx <= '0;
    end else if (isLast) begin
      drainOn  <= 1'b1;
      drainIdx <= '0;
    end else if (drainOn) begin
      if (drainIdx == lastCol) begin
        drainOn  <= 1'b0;
        drainIdx <= '0;
      end else begin
        drainIdx <= drainIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.accept = accept;
    strb.first  = accept && (colCnt == '0);
    strb.last   = isLast;
    strb.clear  = cfgWe;
    strb.dual   = dualReg;
    strb.srcDin = srcReg;
    strb.col    = colCnt;
  end

  assign outValidA = drainOn;
  assign outValidB = drainOn && dualReg;
  assign outLast   = drainOn && (drainIdx == lastCol);
  assign outIdx    = drainIdx;
endmodule

// File: rtl/mvm_datapath.sv
module mvm_datapath
  import mvm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  mvStrobes_t              strb,
  input  logic                    coefWe,
  input  logic [IdxW-1:0]         coefSet,
  input  logic [IdxW-1:0]         coefCol,
  input  logic signed [CoefW-1:0] coefData,
  input  logic signed [DataW-1:0] dIn,
  input  logic signed [DataW-1:0] rIn,
  input  logic [IdxW-1:0]         outIdx,
  input  logic                    outValidA,
  input  logic                    outValidB,
  output logic signed [ResW-1:0]  resA,
  output logic signed [ResW-1:0]  resB
);
  logic signed [CoefW-1:0] stageCoef [MaxN][MaxN];
  logic signed [CoefW-1:0] actCoef   [MaxN][MaxN];
  logic signed [ResW-1:0]  resWord   [MaxN];
  logic signed [DataW-1:0] dataB;
  logic [IdxW-1:0]         idxB;

  // host-facing staging store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MaxN; s++)
        for (int c = 0; c < MaxN; c++)
          stageCoef[s][c] <= '0;
    end else if (coefWe) begin
      stageCoef[coefSet][coefCol] <= coefData;
    end
  end

  // active copy, refreshed when a vector begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MaxN; s++)
        for (int c = 0; c < MaxN; c++)
          actCoef[s][c] <= '0;
    end else if (strb.first) begin
      actCoef <= stageCoef;
    end
  end

  assign dataB = (strb.dual && !strb.srcDin) ? rIn : dIn;

  for (genvar r = 0; r < MaxN; r++) begin : gRow
    logic signed [CoefW-1:0] cSel;
    logic signed [DataW-1:0] dSel;
    logic signed [ProdW-1:0] prod;
    logic signed [AccW-1:0]  sumNext;
    logic signed [AccW-1:0]  acc;
    logic signed [ResW-1:0]  held;

    // element 0 reads the staging store directly, as the active copy updates at this edge
    assign cSel = strb.first ? stageCoef[r][strb.col] : actCoef[r][strb.col];

    if (r >= HalfN) begin : gUpper
      assign dSel = dataB;
    end else begin : gLower
      assign dSel = dIn;
    end

    assign prod    = ProdW'(cSel) * ProdW'(dSel);
    assign sumNext = acc + AccW'(prod);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        acc <= '0;
      else if (strb.clear)
        acc <= '0;
      else if (strb.accept)
        acc <= strb.last ? '0 : sumNext;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        held <= '0;
      else if (strb.last)
        held <= satRes(sumNext);
    end

    assign resWord[r] = held;
  end

  assign idxB = IdxW'(HalfN) + outIdx;
  assign resA = outValidA ? resWord[outIdx] : '0;
  assign resB = outValidB ? resWord[idxB]   : '0;
endmodule

// File: rtl/mvm_engine.sv
module mvm_engine
  import mvm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [CfgW-1:0]         cfgWdata,
  input  logic                    coefWe,
  input  logic [IdxW-1:0]         coefSet,
  input  logic [IdxW-1:0]         coefCol,
  input  logic signed [CoefW-1:0] coefData,
  input  logic                    dValid,
  input  logic signed [DataW-1:0] dIn,
  input  logic signed [DataW-1:0] rIn,
  output logic                    resValidA,
  output logic signed [ResW-1:0]  resA,
  output logic                    resValidB,
  output logic signed [ResW-1:0]  resB,
  output logic [IdxW-1:0]         resIdx,
  output logic                    resLast
);
  mvStrobes_t strb;

  mvm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .dValid   (dValid),
    .strb     (strb),
    .outValidA(resValidA),
    .outValidB(resValidB),
    .outLast  (resLast),
    .outIdx   (resIdx)
  );

  mvm_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .coefWe   (coefWe),
    .coefSet  (coefSet),
    .coefCol  (coefCol),
    .coefData (coefData),
    .dIn      (dIn),
    .rIn      (rIn),
    .outIdx   (resIdx),
    .outValidA(resValidA),
    .outValidB(resValidB),
    .resA     (resA),
    .resB     (resB)
  );
endmodule

// File: rtl/mvm_engine_chk.sv
module mvm_engine_chk
  import mvm_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            cfgWe,
  input logic            resValidA,
  input logic            resValidB,
  input logic            resLast,
  input logic [IdxW-1:0] resIdx
);
  p_validb_with_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValidB |-> resValidA);

  p_validb_low_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValidB |-> (resIdx < IdxW'(HalfN)));

  p_last_is_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    resLast |-> resValidA);

  p_idx_steps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValidA && !resLast && !cfgWe) |=> (resValidA && (resIdx == $past(resIdx) + 1'b1)));

  p_cfg_stops_drain_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> !resValidA);

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!resValidA && !resValidB && !resLast);
    end
  end
endmodule

bind mvm_engine mvm_engine_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .resValidA(resValidA),
  .resValidB(resValidB),
  .resLast  (resLast),
  .resIdx   (resIdx)
);

// File: tb/mvm_engine_tb_top.sv
module mvm_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic coefWe = 1'b0;
  logic [3:0] coefSet = '0;
  logic [3:0] coefCol = '0;
  logic signed [11:0] coefData = '0;
  logic dValid = 1'b0;
  logic signed [11:0] dIn = '0;
  logic signed [11:0] rIn = '0;
  logic resValidA, resValidB, resLast;
  logic signed [15:0] resA, resB;
  logic [3:0] resIdx;

  always #4 clk = ~clk;

  mvm_engine dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .coefWe(coefWe), .coefSet(coefSet), .coefCol(coefCol), .coefData(coefData),
    .dValid(dValid), .dIn(dIn), .rIn(rIn),
    .resValidA(resValidA), .resA(resA), .resValidB(resValidB), .resB(resB),
    .resIdx(resIdx), .resLast(resLast)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int mC [16][16];
  int vD [2][16];
  int vR [2][16];
  int expRes [2][16];
  int midK [2] = '{-1, -1};
  int midS [2];
  int midC [2];
  int midV [2];

  // {cfg byte, value kind, seed, unused}
  localparam logic [31:0] Cases [6] = '{
    {8'h14, 8'd0, 8'd1, 8'd0},
    {8'h12, 8'd0, 8'd2, 8'd0},
    {8'h16, 8'd0, 8'd3, 8'd0},
    {8'h14, 8'd1, 8'd0, 8'd0},
    {8'h12, 8'd2, 8'd0, 8'd0},
    {8'h14, 8'd0, 8'd4, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int satI(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int coefVal(input int kind, input int seed, input int s, input int c);
    case (kind)
      1: return 2047;
      2: return -2048;
      3: return 0;
      default: return ((s * 37 + c * 11 + seed * 5) % 64) - 32;
    endcase
  endfunction

  task automatic genVec(input int v, input int kind, input int seed);
    for (int j = 0; j < 16; j++) begin
      if (kind == 1 || kind == 2) begin
        vD[v][j] = 2047;
        vR[v][j] = 2047;
      end else begin
        vD[v][j] = ((j * 19 + seed * 31 + 7) % 256) - 128;
        vR[v][j] = ((j * 23 + seed * 17 + 3) % 256) - 128;
      end
    end
  endtask

  task automatic computeExp(input int v, input bit dual, input bit srcDin);
    int n;
    longint sum;
    n = dual ? 8 : 16;
    for (int r = 0; r < 16; r++) begin
      sum = 0;
      for (int j = 0; j < n; j++)
        sum += longint'(mC[r][j]) * ((dual && r >= 8 && !srcDin) ? vR[v][j] : vD[v][j]);
      expRes[v][r] = satI(sum);
    end
  endtask

  task automatic writeCfg(input logic [7:0] val);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadCoefs(input int kind, input int seed);
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        mC[s][c] = coefVal(kind, seed, s, c);
        coefWe = 1'b1;
        coefSet = 4'(s);
        coefCol = 4'(c);
        coefData = 12'(mC[s][c]);
      end
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  // streams nvec gapless vectors and checks every output cycle
  task automatic runStream(input int nvec, input bit dual, input bit srcDin, input string tag);
    int n;
    int q;
    int v;
    int p;
    n = dual ? 8 : 16;
    computeExp(0, dual, srcDin);
    for (int m = 0; m < 2; m++)
      if (midK[m] >= 0) mC[midS[m]][midC[m]] = midV[m];
    if (nvec > 1) computeExp(1, dual, srcDin);
    for (int k = 0; k < nvec * n + n + 2; k++) begin
      @(negedge clk);
      q = k - n;
      if (q >= 0 && q / n < nvec) begin
        v = q / n;
        p = q % n;
        chk(resValidA == 1'b1, "R7", "resValidA", int'(resValidA), 1);
        chk(resIdx == 4'(p), "R7", "resIdx", int'(resIdx), p);
        chk(resLast == (p == n - 1), "R7", "resLast", int'(resLast), int'(p == n - 1));
        chk(int'(resA) == expRes[v][p], tag, "resA", int'(resA), expRes[v][p]);
        if (dual) begin
          chk(resValidB == 1'b1, "R5", "resValidB", int'(resValidB), 1);
          chk(int'(resB) == expRes[v][8 + p], tag, "resB", int'(resB), expRes[v][8 + p]);
        end else begin
          chk(resValidB == 1'b0, "R5", "resValidB single", int'(resValidB), 0);
        end
      end else begin
        chk(resValidA == 1'b0, "R7", "resValidA idle", int'(resValidA), 0);
        chk(resA == 16'sd0, "R7", "resA idle", int'(resA), 0);
      end
      coefWe = 1'b0;
      for (int m = 0; m < 2; m++)
        if (midK[m] == k) begin
          coefWe = 1'b1;
          coefSet = 4'(midS[m]);
          coefCol = 4'(midC[m]);
          coefData = 12'(midV[m]);
        end
      if (k < nvec * n) begin
        dValid = 1'b1;
        dIn = 12'(vD[k / n][k % n]);
        rIn = 12'(vR[k / n][k % n]);
      end else begin
        dValid = 1'b0;
      end
    end
    coefWe = 1'b0;
    midK[0] = -1;
    midK[1] = -1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] cfgV;
    int kind;
    int seed;
    bit dual;
    bit srcDin;
    string tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(resValidA == 1'b0, "R1", "resValidA in reset", int'(resValidA), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(resValidA == 1'b0 && resValidB == 1'b0, "R1", "valids after reset", int'({resValidA, resValidB}), 0);
    chk(resLast == 1'b0, "R1", "resLast after reset", int'(resLast), 0);
    // R1/R2: engine disabled at reset, elements ignored
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k > 0) chk(resValidA == 1'b0, "R1", "no result while disabled", int'(resValidA), 0);
      dValid = (k < 16);
      dIn = 12'(k * 5);
    end

    // table-driven cases
    for (int t = 0; t < 6; t++) begin
      cfgV = Cases[t][31:24];
      kind = int'(Cases[t][23:16]);
      seed = int'(Cases[t][15:8]);
      dual = cfgV[1];
      srcDin = cfgV[2];
      writeCfg(cfgV);
      loadCoefs(kind, seed);
      genVec(0, kind, seed);
      if (kind != 0) tag = "R6";
      else if (dual) tag = "R5";
      else tag = "R4";
      runStream(1, dual, srcDin, tag);
    end

    // R3: a single nonzero coefficient in row 9, column 2, dual with B from dIn
    writeCfg(8'h16);
    loadCoefs(3, 0);
    @(negedge clk);
    coefWe = 1'b1; coefSet = 4'd9; coefCol = 4'd2; coefData = 12'sd5; mC[9][2] = 5;
    @(negedge clk);
    coefWe = 1'b0;
    genVec(0, 0, 6);
    runStream(1, 1'b1, 1'b1, "R3");

    // R8: two gapless vectors in single mode
    writeCfg(8'h14);
    loadCoefs(0, 7);
    genVec(0, 0, 8);
    genVec(1, 0, 9);
    runStream(2, 1'b0, 1'b0, "R8");

    // R9: writes at element 0 and element 3 of the first vector affect only the second
    writeCfg(8'h12);
    loadCoefs(0, 10);
    genVec(0, 0, 11);
    genVec(1, 0, 12);
    midK[0] = 0; midS[0] = 5;  midC[0] = 0; midV[0] = 1500;
    midK[1] = 3; midS[1] = 12; midC[1] = 2; midV[1] = -1900;
    runStream(2, 1'b1, 1'b0, "R9");

    // R10: a partial vector is discarded by a configuration write
    writeCfg(8'h14);
    loadCoefs(0, 13);
    genVec(1, 0, 14);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      dValid = 1'b1;
      dIn = 12'(vD[1][k]);
    end
    @(negedge clk);
    dValid = 1'b0;
    writeCfg(8'h14);
    genVec(0, 0, 15);
    runStream(1, 1'b0, 1'b0, "R10");

    // R10: a result sequence in progress is cut off
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      dValid = 1'b1;
      dIn = 12'(vD[0][k]);
    end
    @(negedge clk);
    dValid = 1'b0;
    @(negedge clk);
    chk(resValidA == 1'b1, "R10", "drain started", int'(resValidA), 1);
    writeCfg(8'h14);
    chk(resValidA == 1'b0, "R10", "drain stopped by cfg write", int'(resValidA), 0);
    @(negedge clk);
    chk(resValidA == 1'b0, "R10", "drain stays stopped", int'(resValidA), 0);

    // R2: bit 4 clear disables the engine even in dual shape
    writeCfg(8'h02);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      chk(resValidA == 1'b0, "R2", "disabled engine output", int'(resValidA), 0);
      dValid = (k < 16);
      dIn = 12'(k);
    end
    dValid = 1'b0;
    writeCfg(8'h12);
    genVec(0, 0, 16);
    runStream(1, 1'b1, 1'b0, "R2");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule